// File: doc/BRIEF.md
# Global Brightness Scaler with Deferred Update

This block turns three 10-bit LED current settings into three scaled current codes. The settings come from one of three banks. A single brightness factor scales all three codes, so the ratios between the channels stay fixed. The factor has three possible sources: a fixed full-scale value, an 8-bit fader value, or the duty cycle measured on a PWM input pin. When the PWM input stops toggling for a timeout, it counts as a steady level.

The colour enable lines pace the block. The scaled codes are recomputed and registered only when a colour begins, which is a rising edge on any enable line. The codes then stay fixed for the rest of that colour. A new brightness factor is adopted at a colour start only if it has been unchanged for at least one timeout before that edge. Otherwise the previous factor is used again, and the new value moves to a later colour. A neighbouring analog stage turns the codes into output current.

Top module: `brightness_scaler`

## Requirements
- R1: The stored settings form nine 10-bit values, with index = bank*3 + channel (channel 0 = red, 1 = green, 2 = blue). Value k is {set_hi[2k+1:2k], set_lo[8k+7:8k]}. The bank code 00 selects bank 0, 01 selects bank 1, and both 10 and 11 select bank 2.
- R2: With mode = {fader_enable, pwm_enable} = 00 the factor is 256 (full scale), so every code equals its selected setting.
- R3: With mode 10 the factor is fader + fader[7]. Fader 255 therefore gives 256 and fader 0 gives 0.
- R4: With mode 01 or 11 and a periodic PWM input, the period is P clocks with H clocks high, where 10 <= P and P < TIMEOUT_CYC. The factor is then floor(256*H/P).
- R5: With mode 01 or 11, when the PWM input shows no edge for TIMEOUT_CYC clocks, the factor becomes 256 if the input is high and 0 if it is low.
- R6: Each code equals floor(setting * factor / 256), and all three channels use the same factor.
- R7: The codes change only at the clock edge that sees a rising edge on any col_en bit. While no such edge occurs, they hold, even if the bank, the settings, the mode, the fader or the PWM input change.
- R8: At a colour start, the candidate factor is adopted only if it has been unchanged for at least TIMEOUT_CYC clocks. Otherwise the previously applied factor is used, and the candidate is adopted at a later colour start that meets the condition.
- R9: After reset all three codes are 0 and the applied factor is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Brightness PWM pin (synchronised inside) |
| col_en | input | 3 | Colour enable lines, synchronous to clk |
| bank_sel | input | 2 | Bank select code |
| mode | input | 2 | {fader_enable, pwm_enable} |
| fader | input | 8 | Fader brightness value |
| set_lo | input | 72 | Low bytes of the nine settings |
| set_hi | input | 18 | High 2-bit fields of the nine settings |
| code_r | output | 10 | Scaled red code |
| code_g | output | 10 | Scaled green code |
| code_b | output | 10 | Scaled blue code |

## Verification
The assertions assume four things about the inputs:
- The PWM input has at least one low clock in every period, so the measured high count stays below the measured period.
- The PWM period is at least ten clocks, so one serial division finishes before the next begins.
- Each PWM phase is shorter than the timeout.
- The enable lines are synchronous to the clock.

The stimulus drives the PWM pin from a generator on the falling clock edge. Its periods run from 12 to 40 clocks, well below the shortened 200-clock timeout. Every change of mode, fader or PWM pattern is followed by a wait of more than three timeouts before a colour starts, except in the one step that deliberately starts a colour too early.

// File: rtl/bs_pkg.sv
package bs_pkg;

    typedef enum logic [1:0] {
        MODE_FLAT  = 2'b00,
        MODE_PWM   = 2'b01,
        MODE_FADE  = 2'b10,
        MODE_PWM_B = 2'b11
    } bright_mode_e;

    // bank code 11 aliases bank 2
    function automatic logic [1:0] bank_of(input logic [1:0] sel);
        return (sel == 2'b11) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/frac_div.sv
// Serial restoring divider: quo = floor(num * 2^Q_W / den), valid when num < den.
module frac_div #(
    parameter int NUM_W = 16,
    parameter int Q_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int CNT_W = $clog2(Q_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] rem;
        logic [NUM_W-1:0] den;
        logic [Q_W-1:0]   quo;
        logic             done;
    } div_st_t;

    div_st_t q, d;
    logic [NUM_W:0] sh_d, diff_d;
    logic           take_d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sh_d   = {q.rem, 1'b0};
        diff_d = sh_d - {1'b0, q.den};
        take_d = (sh_d >= {1'b0, q.den});
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.rem  = num;
            d.den  = den;
            d.quo  = '0;
        end else if (q.busy) begin
            d.rem = take_d ? NUM_W'(diff_d) : NUM_W'(sh_d);
            d.quo = {q.quo[Q_W-2:0], take_d};
            if (q.cnt == CNT_W'(Q_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.quo;

    // R4: the meter hands over a high count below the period
    a_r4_operand_order: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (num < den));
    // R4: a period is long enough for the previous division to finish
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

endmodule

// File: rtl/duty_meter.sv
// Measures PWM duty as a 9-bit factor (256 = full); falls back to level after a timeout.
// Requires 2*TIMEOUT_CYC < 2**PER_W.
module duty_meter #(
    parameter int PER_W       = 16,
    parameter int FRAC_W      = 8,
    parameter int TIMEOUT_CYC = 15000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    output logic [FRAC_W:0] duty
);
    localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [FRAC_W:0] FULL = (FRAC_W + 1)'(1) << FRAC_W;

    typedef struct packed {
        logic [1:0]        sync;
        logic              lvl;
        logic [PER_W-1:0]  per;
        logic [PER_W-1:0]  hi;
        logic [IDLE_W-1:0] idle;
        logic              armed;
        logic [FRAC_W:0]   duty;
    } meter_st_t;

    meter_st_t q, d;
    logic pwm_s, rise, edge_any, steady, div_start, div_done;
    logic [FRAC_W-1:0] div_quo;

    assign pwm_s     = q.sync[1];
    assign rise      = pwm_s & ~q.lvl;
    assign edge_any  = pwm_s ^ q.lvl;
    assign steady    = (q.idle == IDLE_W'(TIMEOUT_CYC)) && !edge_any;
    assign div_start = rise & q.armed;

    frac_div #(.NUM_W(PER_W), .Q_W(FRAC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (q.hi),
        .den   (q.per),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], pwm_in};
        d.lvl  = pwm_s;
        if (rise) begin
            d.per = PER_W'(1);
            d.hi  = PER_W'(1);
        end else begin
            if (q.per != '1)          d.per = q.per + 1'b1;
            if (pwm_s && q.hi != '1)  d.hi  = q.hi + 1'b1;
        end
        if (edge_any)                              d.idle = '0;
        else if (q.idle != IDLE_W'(TIMEOUT_CYC))   d.idle = q.idle + 1'b1;
        if (rise)        d.armed = 1'b1;
        else if (steady) d.armed = 1'b0;
        if (div_done) d.duty = {1'b0, div_quo};
        if (steady)   d.duty = pwm_s ? FULL : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign duty = q.duty;

    // R5: after a silent timeout the factor is one of the two level values
    a_r5_steady_level: assert property (@(posedge clk) disable iff (!rst_n)
        steady |=> (q.duty == '0 || q.duty == FULL));

endmodule

// File: rtl/factor_gate.sv
// Holds the applied factor; adopts the candidate at a colour start only once it is old enough.
module factor_gate #(
    parameter int F_W         = 9,
    parameter int TIMEOUT_CYC = 15000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [F_W-1:0] cand,
    output logic [F_W-1:0] f_now
);
    localparam int AGE_W = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [F_W-1:0]   prev;
        logic [AGE_W-1:0] age;
        logic [F_W-1:0]   app;
    } gate_st_t;

    gate_st_t q, d;
    logic ripe;

    assign ripe  = (q.age == AGE_W'(TIMEOUT_CYC)) && (cand == q.prev);
    assign f_now = (start && ripe) ? cand : q.app;

    always_comb begin
        d      = q;
        d.prev = cand;
        if (cand != q.prev)                        d.age = '0;
        else if (q.age != AGE_W'(TIMEOUT_CYC))     d.age = q.age + 1'b1;
        if (start && ripe) d.app = cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a start with an unripe candidate keeps the applied factor
    a_r8_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ripe) |=> (q.app == $past(q.app)));
    // R8: the applied factor moves only at a colour start
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(q.app));

endmodule

// File: rtl/brightness_scaler.sv
module brightness_scaler
    import bs_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int LO_W        = 8,
    parameter int FRAC_W      = 8,
    parameter int PER_W       = 16,
    parameter int TIMEOUT_CYC = 15000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwm_in,
    input  logic [2:0]             col_en,
    input  logic [1:0]             bank_sel,
    input  logic [1:0]             mode,
    input  logic [FRAC_W-1:0]      fader,
    input  logic [9*LO_W-1:0]      set_lo,
    input  logic [9*(CODE_W-LO_W)-1:0] set_hi,
    output logic [CODE_W-1:0]      code_r,
    output logic [CODE_W-1:0]      code_g,
    output logic [CODE_W-1:0]      code_b
);
    localparam int N_CH  = 3;
    localparam int N_SET = 9;
    localparam int HI_W  = CODE_W - LO_W;
    localparam int F_W   = FRAC_W + 1;
    localparam int SI_W  = $clog2(N_SET);
    localparam int P_W   = CODE_W + F_W;
    localparam logic [F_W-1:0] FULL = F_W'(1) << FRAC_W;

    typedef struct packed {
        logic [N_CH-1:0]             en;
        logic [N_CH-1:0][CODE_W-1:0] code;
    } top_st_t;

    top_st_t q, d;
    logic                        start;
    logic [F_W-1:0]              duty, cand, f_now;
    logic [1:0]                  bidx;
    logic [N_CH-1:0][CODE_W-1:0] sett, scaled;

    assign start = |(col_en & ~q.en);
    assign bidx  = bank_of(bank_sel);

    duty_meter #(.PER_W(PER_W), .FRAC_W(FRAC_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_in (pwm_in),
        .duty   (duty)
    );

    always_comb begin
        case (bright_mode_e'(mode))
            MODE_FLAT: cand = FULL;
            MODE_FADE: cand = {1'b0, fader} + F_W'(fader[FRAC_W-1]);
            default:   cand = duty;
        endcase
    end

    factor_gate #(.F_W(F_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .cand  (cand),
        .f_now (f_now)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [SI_W-1:0] sidx;
        logic [P_W-1:0]  prod;
        assign sidx      = SI_W'(bidx) * SI_W'(N_CH) + SI_W'(c);
        assign sett[c]   = {set_hi[sidx*HI_W +: HI_W], set_lo[sidx*LO_W +: LO_W]};
        assign prod      = P_W'(sett[c]) * P_W'(f_now);
        assign scaled[c] = CODE_W'(prod >> FRAC_W);

        // R6: a scaled code never exceeds the setting it came from
        a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> (q.code[c] <= $past(sett[c])));
    end

    always_comb begin
        d    = q;
        d.en = col_en;
        if (start) d.code = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code_r = q.code[0];
    assign code_g = q.code[1];
    assign code_b = q.code[2];

    // R7: codes hold between colour starts
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(q.code));

endmodule

// File: tb/brightness_scaler_test.sv
`timescale 1ns/1ps
module brightness_scaler_test;

    localparam int TMO = 200;

    typedef struct packed {
        logic [1:0] md;
        logic [1:0] bk;
        logic [7:0] fd;
        logic [7:0] ph;
        logic [7:0] pp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 2'd0, 8'd0,   8'd0,  8'd0},
        '{2'b00, 2'd1, 8'd0,   8'd0,  8'd0},
        '{2'b00, 2'd2, 8'd0,   8'd0,  8'd0},
        '{2'b00, 2'd3, 8'd0,   8'd0,  8'd0},
        '{2'b10, 2'd0, 8'd200, 8'd0,  8'd0},
        '{2'b10, 2'd1, 8'd255, 8'd0,  8'd0},
        '{2'b10, 2'd2, 8'd100, 8'd0,  8'd0},
        '{2'b01, 2'd0, 8'd0,   8'd16, 8'd32},
        '{2'b11, 2'd1, 8'd0,   8'd30, 8'd37},
        '{2'b01, 2'd2, 8'd0,   8'd5,  8'd40},
        '{2'b01, 2'd0, 8'd0,   8'd1,  8'd0},
        '{2'b11, 2'd1, 8'd0,   8'd0,  8'd0},
        '{2'b01, 2'd2, 8'd0,   8'd3,  8'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_in = 1'b0;
    logic [2:0]  col_en = '0;
    logic [1:0]  bank_sel = '0;
    logic [1:0]  m_mode = '0;
    logic [7:0]  fader = '0;
    logic [71:0] set_lo;
    logic [17:0] set_hi;
    logic [9:0]  code_r, code_g, code_b;
    int gen_h = 0;
    int gen_p = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    brightness_scaler #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .col_en(col_en),
        .bank_sel(bank_sel), .mode(m_mode), .fader(fader),
        .set_lo(set_lo), .set_hi(set_hi),
        .code_r(code_r), .code_g(code_g), .code_b(code_b)
    );

    function automatic int sval(input int i);
        case (i)
            0: return 1023; 1: return 487; 2: return 333;
            3: return 129;  4: return 600; 5: return 1000;
            6: return 682;  7: return 5;   default: return 777;
        endcase
    endfunction

    function automatic int bank_idx(input int b);
        return (b == 3) ? 2 : b;
    endfunction

    function automatic int exp_f(input vec_t v);
        if (v.md == 2'b00) return 256;
        if (v.md == 2'b10) return int'(v.fd) + int'(v.fd[7]);
        if (v.pp == 0)     return (v.ph != 0) ? 256 : 0;
        return (int'(v.ph) * 256) / int'(v.pp);
    endfunction

    function automatic string tag_of(input vec_t v);
        if (v.bk == 2'd3)  return "R1";
        if (v.md == 2'b00) return "R2";
        if (v.md == 2'b10) return "R3";
        if (v.pp == 0)     return "R5";
        return "R4";
    endfunction

    function automatic int got(input int c);
        case (c)
            0: return int'(code_r);
            1: return int'(code_g);
            default: return int'(code_b);
        endcase
    endfunction

    task automatic check(input string tag, input int c, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s ch%0d: actual %0d expected %0d", tag, c, act, expv);
        end
    endtask

    task automatic check_bank(input string tag, input int b, input int f);
        for (int c = 0; c < 3; c++)
            check(tag, c, got(c), (sval(bank_idx(b) * 3 + c) * f) >> 8);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic colour(input int ch);
        col_en = 3'(1 << ch);
        repeat (3) @(negedge clk);
    endtask

    task automatic off;
        col_en = '0;
        repeat (2) @(negedge clk);
    endtask

    // PWM generator, changes only on the falling clock edge
    initial begin
        forever begin
            if (gen_p == 0) begin
                pwm_in = (gen_h != 0);
                @(negedge clk);
            end else begin
                pwm_in = 1'b1;
                repeat (gen_h) @(negedge clk);
                pwm_in = 1'b0;
                repeat (gen_p - gen_h) @(negedge clk);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 9; i++) begin
            logic [9:0] v;
            v = 10'(sval(i));
            set_lo[i*8 +: 8] = v[7:0];
            set_hi[i*2 +: 2] = v[9:8];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check_bank("R9", 0, 0);
        repeat (3 * TMO + 50) @(negedge clk);
        // R7: no colour start yet, so nothing may change
        check_bank("R7", 0, 0);

        // R6: scaling across modes, banks and PWM patterns
        for (int i = 0; i < NV; i++) begin
            m_mode   = VEC[i].md;
            bank_sel = VEC[i].bk;
            fader    = VEC[i].fd;
            gen_h    = int'(VEC[i].ph);
            gen_p    = int'(VEC[i].pp);
            repeat (3 * TMO + 50) @(negedge clk);
            colour(i % 3);
            check_bank($sformatf("%s/R6 vec%0d", tag_of(VEC[i]), i), int'(VEC[i].bk), exp_f(VEC[i]));
            off();
        end

        // R7: hold while a colour stays active
        gen_h = 0; gen_p = 0;
        m_mode = 2'b00; bank_sel = 2'd0;
        repeat (3 * TMO + 50) @(negedge clk);
        colour(0);
        check_bank("R2", 0, 256);
        bank_sel = 2'd1; m_mode = 2'b10; fader = 8'd50;
        repeat (3 * TMO + 50) @(negedge clk);
        check_bank("R7", 0, 256);
        off();

        // R8: ripe candidate adopted, then an early start defers the next one
        colour(1);
        check_bank("R8 ripe", 1, 50);
        off();
        fader = 8'd150;
        repeat (20) @(negedge clk);
        colour(2);
        check_bank("R8 early", 1, 50);
        off();
        repeat (3 * TMO + 50) @(negedge clk);
        colour(0);
        check_bank("R8 later", 1, 151);
        off();

        summary();
    end

endmodule